// File: doc/BRIEF.md
# Lane-Partitioned Adder and Comparator

A purely combinational arithmetic unit for 32-bit operands. A partition mode decides how the word is cut into lanes: one 32-bit lane, two 16-bit lanes, or four 8-bit lanes. A single chain of 8-bit adder slices carries out every operation. In the narrower modes the carry is cut at the lane edges, so each lane adds or subtracts on its own.

Compare operations return a mask for each lane. A true lane has every bit set and a false lane is all zeros. Software can AND such a mask straight into a select without first spreading a flag across the lane. Add and subtract also report a carry or borrow flag for each active lane.

Top module: `lane_alu`

## Requirements
- R1: With mode 0 (word; the reserved mode 3 behaves the same), op 0 (add) returns the sum of the two operands modulo 2^32.
- R2: With mode 2 (byte), each 8-bit lane k (bits 8k+7..8k) of the result is the sum or difference of lane k of each operand modulo 2^8. No carry or borrow crosses into bits 8, 16 or 24.
- R3: With mode 1 (half), each 16-bit lane is computed independently. The carry is cut only at bit 16.
- R4: Op 1 (subtract) returns a minus b modulo the lane width in every mode.
- R5: On add, flag bit g is the carry out of lane g. Lanes are numbered from the least significant end.
- R6: On subtract, flag bit g is 1 when lane g of a is unsigned-less than lane g of b, meaning a borrow.
- R7: Flag bits with no active lane read 0: bits 3..1 in word mode and bits 3..2 in half mode. All flags read 0 for compare ops and for unused op codes.
- R8: Op 2 (equal) sets every bit of a lane when the two operand lanes are equal, and clears every bit of the lane otherwise.
- R9: Op 3 (unsigned less-than) sets the lane to all ones when a is unsigned-less than b within that lane, and to zeros otherwise.
- R10: Op 4 (signed less-than) sets the lane to all ones when a is less than b as two's-complement lane values, and to zeros otherwise.
- R11: Op codes 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | 0 add, 1 sub, 2 eq, 3 ltu, 4 lts, 5-7 unused |
| mode_i | input | 2 | 0 word, 1 half, 2 byte, 3 same as word |
| result_o | output | 32 | Sum, difference or lane mask |
| flag_o | output | 4 | Per-lane carry (add) or borrow (sub) |

## Verification
The bench sweeps every mode and op code over operands built from the lane corner values 00, 01, 7F, 80, FE and FF, mixed with pseudo-random words. These choices put carries and borrows exactly on the lane edges.

A design that leaked carry across a cut would corrupt the next lane up in byte or half mode. A design that forgot the carry-in of 1 on a lane start during subtract would be off by one in the upper lanes. Comparing signed values only through the borrow would get lane pairs such as 7F against 80 backwards. A design that drove the compare result as a single bit instead of a mask would produce lanes that are neither 00 nor FF. Flags from inactive boundaries leaking out would show up in the upper bits of flag_o.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned NUM_LANES = 4;

  typedef enum logic [1:0] {
    PART_WORD = 2'd0,
    PART_HALF = 2'd1,
    PART_BYTE = 2'd2,
    PART_RSVD = 2'd3
  } part_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_EQ  = 3'd2,
    OP_LTU = 3'd3,
    OP_LTS = 3'd4
  } alu_op_e;

  // bytes per lane for a partition mode
  function automatic int unsigned group_size(input logic [1:0] mode, input int unsigned nl);
    case (mode)
      PART_BYTE: group_size = 1;
      PART_HALF: group_size = nl / 2;
      default:   group_size = nl;
    endcase
  endfunction
endpackage

// File: rtl/lane_boundary_gen.sv
module lane_boundary_gen
  import lane_alu_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input  logic [1:0]           mode_i,
  output logic [NUM_LANES-1:0] seg_start_o,
  output logic [NUM_LANES-1:0] seg_end_o
);
  logic is_byte, is_half;
  assign is_byte = (mode_i == PART_BYTE);
  assign is_half = (mode_i == PART_HALF);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_start
    if (k == 0) begin : g_lsb
      assign seg_start_o[k] = 1'b1;
    end else if (k == NUM_LANES / 2) begin : g_mid
      assign seg_start_o[k] = is_byte | is_half;
    end else begin : g_inner
      assign seg_start_o[k] = is_byte;
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_end
    if (k == NUM_LANES - 1) begin : g_msb
      assign seg_end_o[k] = 1'b1;
    end else begin : g_cut
      assign seg_end_o[k] = seg_start_o[k+1];
    end
  end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic                 invert_b_i,
  input  logic [NUM_LANES-1:0] seg_start_i,
  output logic [DATA_W-1:0]    sum_o,
  output logic [NUM_LANES-1:0] cout_o
);
  logic [NUM_LANES-1:0] cin;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_slice
    logic [LANE_W-1:0] a_s, b_s;
    logic [LANE_W:0]   s;
    assign a_s = a_i[k*LANE_W +: LANE_W];
    assign b_s = b_i[k*LANE_W +: LANE_W] ^ {LANE_W{invert_b_i}};
    if (k == 0) begin : g_first
      assign cin[k] = invert_b_i;
    end else begin : g_chain
      // a lane start takes the fresh carry-in instead of the neighbour's carry
      assign cin[k] = seg_start_i[k] ? invert_b_i : cout_o[k-1];
    end
    assign s = {1'b0, a_s} + {1'b0, b_s} + {{LANE_W{1'b0}}, cin[k]};
    assign sum_o[k*LANE_W +: LANE_W] = s[LANE_W-1:0];
    assign cout_o[k] = s[LANE_W];
  end
endmodule

// File: rtl/seg_compare.sv
module seg_compare
  import lane_alu_pkg::*;
#(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic [1:0]           mode_i,
  input  logic [2:0]           op_i,
  input  logic [NUM_LANES-1:0] cout_i,
  output logic [NUM_LANES-1:0] hit_o
);
  logic [NUM_LANES-1:0] byte_eq;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_eq
    assign byte_eq[k] = (a_i[k*LANE_W +: LANE_W] == b_i[k*LANE_W +: LANE_W]);
  end

  always_comb begin
    int unsigned gs;
    gs = group_size(mode_i, NUM_LANES);
    hit_o = '0;
    for (int unsigned k = 0; k < NUM_LANES; k++) begin
      int unsigned lo, hi;
      logic eq, ltu, lts, sa, sb;
      lo = (k / gs) * gs;
      hi = lo + gs - 1;
      eq = 1'b1;
      for (int unsigned j = 0; j < NUM_LANES; j++) begin
        if (j >= lo && j <= hi) eq = eq & byte_eq[j];
      end
      ltu = ~cout_i[hi];              // borrow out of the lane's top slice
      sa  = a_i[hi*LANE_W + LANE_W - 1];
      sb  = b_i[hi*LANE_W + LANE_W - 1];
      lts = (sa != sb) ? sa : ltu;
      case (op_i)
        OP_EQ:   hit_o[k] = eq;
        OP_LTU:  hit_o[k] = ltu;
        OP_LTS:  hit_o[k] = lts;
        default: hit_o[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int unsigned LANE_W    = lane_alu_pkg::LANE_W,
  parameter int unsigned NUM_LANES = lane_alu_pkg::NUM_LANES,
  localparam int unsigned DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic [2:0]           op_i,
  input  logic [1:0]           mode_i,
  output logic [DATA_W-1:0]    result_o,
  output logic [NUM_LANES-1:0] flag_o
);
  logic [NUM_LANES-1:0] seg_start, seg_end, cout, hit;
  logic [DATA_W-1:0]    sum;
  logic                 is_arith, is_sub, is_cmp;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign is_sub   = (op_i != OP_ADD);
  assign is_cmp   = (op_i == OP_EQ) || (op_i == OP_LTU) || (op_i == OP_LTS);

  lane_boundary_gen #(.NUM_LANES(NUM_LANES)) u_bounds (
    .mode_i      (mode_i),
    .seg_start_o (seg_start),
    .seg_end_o   (seg_end)
  );

  seg_adder #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_adder (
    .a_i         (a_i),
    .b_i         (b_i),
    .invert_b_i  (is_sub),
    .seg_start_i (seg_start),
    .sum_o       (sum),
    .cout_o      (cout)
  );

  seg_compare #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_cmp (
    .a_i    (a_i),
    .b_i    (b_i),
    .mode_i (mode_i),
    .op_i   (op_i),
    .cout_i (cout),
    .hit_o  (hit)
  );

  always_comb begin
    result_o = '0;
    if (is_arith) begin
      result_o = sum;
    end else if (is_cmp) begin
      for (int unsigned k = 0; k < NUM_LANES; k++)
        result_o[k*LANE_W +: LANE_W] = {LANE_W{hit[k]}};
    end
  end

  // carry/borrow reported at the top slice of each active lane
  always_comb begin
    int unsigned gs;
    gs = group_size(mode_i, NUM_LANES);
    flag_o = '0;
    if (is_arith) begin
      for (int unsigned k = 0; k < NUM_LANES; k++) begin
        if (seg_end[k]) flag_o[k / gs] = cout[k] ^ is_sub;
      end
    end
  end

  // ---------------- assertions ----------------
  logic word_mode;
  assign word_mode = (mode_i == PART_WORD) || (mode_i == PART_RSVD);

  always_comb begin
    if (word_mode && op_i == OP_ADD) begin
      a_r1_word_add: assert (result_o == a_i + b_i);
      a_r5_word_carry: assert (flag_o[0] == (({1'b0, a_i} + {1'b0, b_i}) >> DATA_W));
    end
    if (word_mode && op_i == OP_SUB) begin
      a_r4_word_sub: assert (result_o == a_i - b_i);
      a_r6_word_borrow: assert (flag_o[0] == (a_i < b_i));
    end
    if (!is_arith) begin
      a_r7_quiet_flags: assert (flag_o == '0);
    end
    if (word_mode) begin
      a_r7_word_flags: assert (flag_o[NUM_LANES-1:1] == '0);
    end
    if (mode_i == PART_HALF) begin
      a_r7_half_flags: assert (flag_o[NUM_LANES-1:2] == '0);
    end
    if (is_cmp) begin
      for (int unsigned k = 0; k < NUM_LANES; k++) begin
        a_r8_full_mask: assert (result_o[k*LANE_W +: LANE_W] == '0 ||
                                result_o[k*LANE_W +: LANE_W] == '1);
      end
    end
    if (!is_arith && !is_cmp) begin
      a_r11_unused_zero: assert (result_o == '0);
    end
  end
endmodule

// File: tb/lane_alu_bench.sv
module lane_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [2:0]  op;
  logic [1:0]  mode;
  logic [3:0]  flg;
  int unsigned n_run = 0, n_fail = 0;
  int unsigned cycles = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  lane_alu u_lane_alu (
    .a_i(a), .b_i(b), .op_i(op), .mode_i(mode), .result_o(res), .flag_o(flg)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_fail = n_fail + 1;
      n_run  = n_run + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic model(input logic [31:0] x, input logic [31:0] y, input logic [2:0] o,
                       input logic [1:0] m, output logic [31:0] r, output logic [3:0] f);
    int w, ng;
    longint unsigned msk, av, bv, top, s;
    w  = (m == 2'd2) ? 8 : (m == 2'd1) ? 16 : 32;
    ng = 32 / w;
    msk = (64'd1 << w) - 1;
    top = 64'd1 << (w - 1);
    r = '0;
    f = '0;
    for (int g = 0; g < ng; g++) begin
      av = (longint'(x) >> (g * w)) & msk;
      bv = (longint'(y) >> (g * w)) & msk;
      s = 0;
      case (o)
        3'd0: begin s = (av + bv) & msk; f[g] = ((av + bv) >> w) != 0; end
        3'd1: begin s = (av - bv) & msk; f[g] = av < bv; end
        3'd2: s = (av == bv) ? msk : 0;
        3'd3: s = (av < bv) ? msk : 0;
        3'd4: s = ((av ^ top) < (bv ^ top)) ? msk : 0;
        default: s = 0;
      endcase
      r = r | 32'(s << (g * w));
    end
  endtask

  function automatic string res_tag(input logic [2:0] o, input logic [1:0] m);
    case (o)
      3'd0: res_tag = (m == 2'd2) ? "R2" : (m == 2'd1) ? "R3" : "R1";
      3'd1: res_tag = (m == 2'd2) ? "R2/R4" : (m == 2'd1) ? "R3/R4" : "R4";
      3'd2: res_tag = "R8";
      3'd3: res_tag = "R9";
      3'd4: res_tag = "R10";
      default: res_tag = "R11";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y,
                       input logic [2:0] o, input logic [1:0] m);
    logic [31:0] er;
    logic [3:0]  ef;
    string ft;
    @(negedge clk);
    a = x; b = y; op = o; mode = m;
    #1;
    model(x, y, o, m, er, ef);
    n_run++;
    if (res !== er) begin
      n_fail++;
      $display("FAIL %s op=%0d mode=%0d a=%h b=%h: act=%h exp=%h",
               res_tag(o, m), o, m, x, y, res, er);
    end
    ft = (o == 3'd0) ? "R5" : (o == 3'd1) ? "R6" : "R7";
    n_run++;
    if (flg !== ef) begin
      n_fail++;
      $display("FAIL %s flags op=%0d mode=%0d a=%h b=%h: act=%b exp=%b",
               ft, o, m, x, y, flg, ef);
    end
    if (m != 2'd2) begin   // R7: inactive flag positions stay zero
      n_run++;
      if (flg[3:2] !== 2'b00 || (m != 2'd1 && flg[1] !== 1'b0)) begin
        n_fail++;
        $display("FAIL R7 inactive flags mode=%0d: act=%b exp=upper zero", m, flg);
      end
    end
  endtask

  function automatic logic [7:0] corner(input logic [2:0] i);
    case (i % 6)
      0: corner = 8'h00;
      1: corner = 8'h01;
      2: corner = 8'h7F;
      3: corner = 8'h80;
      4: corner = 8'hFE;
      default: corner = 8'hFF;
    endcase
  endfunction

  initial begin
    logic [31:0] lfsr;
    a = '0; b = '0; op = '0; mode = '0;
    lfsr = 32'h1ACE_B00C;
    // idle state: zero operands give zero result and flags
    apply(32'h0, 32'h0, 3'd0, 2'd0);
    // directed lane-edge cases
    apply(32'h00FF_00FF, 32'h0001_0001, 3'd0, 2'd2);  // R2 carry must not cross
    apply(32'h0000_FFFF, 32'h0000_0001, 3'd0, 2'd1);  // R3
    apply(32'h0000_FFFF, 32'h0000_0001, 3'd0, 2'd0);  // R1
    apply(32'h0000_0000, 32'h0101_0101, 3'd1, 2'd2);  // R4/R6 borrow per lane
    apply(32'h7F80_7F80, 32'h807F_807F, 3'd4, 2'd2);  // R10 signed vs unsigned
    apply(32'h7F80_7F80, 32'h807F_807F, 3'd3, 2'd2);  // R9
    apply(32'h1234_5678, 32'h1234_5678, 3'd2, 2'd0);  // R8
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 8; o++) begin
        for (int i = 0; i < 1800; i++) begin
          logic [31:0] x, y;
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          if (i < 1296) begin
            // pairwise corner bytes with rotation across lanes
            x = {corner(3'(i % 6)), corner(3'((i / 6) % 6)),
                 corner(3'((i / 36) % 6)), corner(3'(i % 6))};
            y = {corner(3'((i / 216) % 6)), corner(3'(i % 6)),
                 corner(3'((i / 6) % 6)), corner(3'((i / 36) % 6))};
          end else begin
            x = lfsr;
            y = {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_A5A5;
            if (i % 4 == 0) y = x;
          end
          apply(x, y, 3'(o), 2'(m));
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule